// File: doc/BRIEF.md
# EISA I/O Slave Glue

This block sits between a 32-bit network controller core and an EISA backplane, where the core acts as an I/O slave. It compares the upper I/O address bits with a base value supplied as a register input and checks that the address-enable line is low. On a match it drives the local-device claim. It also drives a no-wait-state request, which lets the bus master shorten the cycle.

The four active-low byte enables choose the active data lanes of the core. They also drive the core's internal A1 line, because the bus A1 pin is not used in this wiring. Only the seven lane patterns a 32-bit slave can serve are accepted. Any other pattern produces no strobe and no data drive, and it sets a sticky error flag.

Command strobes toward the core last exactly half a BCLK. The block builds them from both clock edges, so a compressed cycle fits in 1.5 BCLK. For type-C slave DMA bursts, the DMA acknowledge acts as a direct chip select. In that mode the block passes the transfer direction to the core. It issues one half-BCLK strobe on every BCLK in which a transfer is requested and the ready-return input reports the bus ready. Otherwise it holds the transfer back.

Top module: `eisa_slave_glue`

## Requirements
- R1: `ldev_n` is low exactly when `addr_hi` equals `io_base` and `aen` is 0, combinationally.
- R2: With `dma_ack_n` high, `be_n` (bit i is the active-low enable of byte lane i) maps to `lane_en = ~be_n` for the supported patterns. These are: all four lanes, lanes 0-1, lanes 2-3, or any single lane. `core_a1` is 1 exactly for the lanes 2-3 pattern and the single lane 2 or lane 3 patterns.
- R3: For any other `be_n` pattern, `lane_en` is 0 and `core_a1` is 0. A decoded I/O cycle with such a pattern gives no read or write strobe and no `data_oe`, and it sets `access_err`.
- R4: `nows_n` is low while the address decodes (R1) until `start_n` has been sampled low at a BCLK rising edge. After that it goes high as soon as `start_n` returns high. It re-arms only after the decode drops.
- R5: `nows_n` is never low while `ldev_n` is high.
- R6: An I/O cycle starts at the first BCLK rising edge where the decode hits, `dma_ack_n` is high and `start_n` is low. The strobe is active from the next falling edge to the next rising edge. It appears on `wr_strobe_n` if `io_wr` was 1 and on `rd_strobe_n` otherwise. `data_oe` is high exactly while the read strobe is active.
- R7: Strobes are half a BCLK wide: both strobes are inactive at every BCLK falling edge, just before it.
- R8: While `dma_ack_n` is low, `dma_cs_n` is low, `core_dir` equals `dma_wr`, `lane_en` is 4'hF and `core_a1` is 0. `dma_cs_n` follows `dma_ack_n` at all times.
- R9: In DMA mode, a rising edge with `cycle_n` low and `ready_ret_n` low yields one half-BCLK strobe, following the timing of R6 and with its direction taken from `dma_wr`. If `ready_ret_n` is high or `cycle_n` is high at that edge, no strobe follows. Back-to-back ready cycles each give a separate strobe.
- R10: Reset clears `access_err` and deactivates both strobes. `access_err` stays set until the next reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| bclk | input | 1 | EISA bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| io_base | input | AW | Programmed I/O base for address bits 15..4 |
| addr_hi | input | AW | Bus address bits 15..4 |
| aen | input | 1 | Address enable, decode only when 0 |
| be_n | input | 4 | Active-low byte enables, bit i for lane i |
| start_n | input | 1 | Active-low cycle start |
| io_wr | input | 1 | 1 for an I/O write into the device |
| dma_ack_n | input | 1 | Active-low DMA acknowledge |
| dma_wr | input | 1 | DMA direction, 1 into the device |
| cycle_n | input | 1 | Active-low DMA transfer request |
| ready_ret_n | input | 1 | Active-low ready return (bus ready) |
| ldev_n | output | 1 | Local device claim |
| nows_n | output | 1 | No-wait-state request |
| lane_en | output | 4 | Active-high byte lane selects to the core |
| core_a1 | output | 1 | Upper half-word select to the core |
| rd_strobe_n | output | 1 | Half-BCLK read strobe |
| wr_strobe_n | output | 1 | Half-BCLK write strobe |
| data_oe | output | 1 | Data bus output enable |
| dma_cs_n | output | 1 | Data path chip select during DMA |
| core_dir | output | 1 | Transfer direction to the core |
| access_err | output | 1 | Sticky unsupported-access flag |

## Verification
I/O cycles are swept over all sixteen byte-enable patterns and both directions. Each runs against four decode situations: a match, `aen` high, a low-order address miss and a high-order address miss. This separates the lane mapping and A1 override from the rejection of illegal patterns, and shows that only decoded cycles produce strobes or errors. DMA bursts are run with every four-cycle ready-return pattern, which tells postponed transfers apart from completed ones. A cycle with `cycle_n` high shows that no transfer happens without a request. Probing each strobe in both half-cycles separates a half-BCLK pulse from a full-cycle one.

// File: rtl/eisa_slave_glue.sv
module eisa_slave_glue #(
  parameter int AW = 12
) (
  input  logic          bclk,
  input  logic          rst_n,
  input  logic [AW-1:0] io_base,
  input  logic [AW-1:0] addr_hi,
  input  logic          aen,
  input  logic [3:0]    be_n,
  input  logic          start_n,
  input  logic          io_wr,
  input  logic          dma_ack_n,
  input  logic          dma_wr,
  input  logic          cycle_n,
  input  logic          ready_ret_n,
  output logic          ldev_n,
  output logic          nows_n,
  output logic [3:0]    lane_en,
  output logic          core_a1,
  output logic          rd_strobe_n,
  output logic          wr_strobe_n,
  output logic          data_oe,
  output logic          dma_cs_n,
  output logic          core_dir,
  output logic          access_err
);

  logic hit, be_ok, seen, go_io, go_dma, go;
  logic arm, arm_wr, tog, tog_n, strobe;

  assign hit = (addr_hi == io_base) && !aen;

  always_comb begin
    case (be_n)
      4'b0000, 4'b1100, 4'b0011,
      4'b1110, 4'b1101, 4'b1011, 4'b0111: be_ok = 1'b1;
      default:                            be_ok = 1'b0;
    endcase
  end

  assign ldev_n   = !hit;
  assign nows_n   = !(hit && !(seen && start_n));
  assign lane_en  = !dma_ack_n ? 4'hF : (be_ok ? ~be_n : 4'h0);
  assign core_a1  = dma_ack_n && be_ok && (be_n[1:0] == 2'b11);
  assign dma_cs_n = dma_ack_n;
  assign core_dir = dma_ack_n ? io_wr : dma_wr;

  assign go_io  = hit && dma_ack_n && !start_n && !seen;
  assign go_dma = !dma_ack_n && !cycle_n && !ready_ret_n;
  assign go     = (go_io && be_ok) || go_dma;

  always_ff @(posedge bclk or negedge rst_n) begin
    if (!rst_n) begin
      seen       <= 1'b0;
      arm        <= 1'b0;
      arm_wr     <= 1'b0;
      tog        <= 1'b0;
      access_err <= 1'b0;
    end else begin
      seen <= hit && (seen || !start_n);
      arm  <= go;
      if (go) begin
        tog    <= ~tog;
        arm_wr <= go_dma ? dma_wr : io_wr;
      end
      if (go_io && !be_ok) access_err <= 1'b1;
    end
  end

  always_ff @(negedge bclk or negedge rst_n) begin
    if (!rst_n) tog_n <= 1'b0;
    else        tog_n <= tog;
  end

  assign strobe      = arm && (tog == tog_n);
  assign rd_strobe_n = !(strobe && !arm_wr);
  assign wr_strobe_n = !(strobe && arm_wr);
  assign data_oe     = strobe && !arm_wr;

  assert_nows_needs_ldev_R5: assert property (@(posedge bclk) disable iff (!rst_n)
    !nows_n |-> !ldev_n);

  assert_half_width_R7: assert property (@(negedge bclk) disable iff (!rst_n)
    rd_strobe_n && wr_strobe_n);

  assert_err_sticky_R10: assert property (@(posedge bclk) disable iff (!rst_n)
    access_err |=> access_err);

  assert_oe_has_lanes_R3: assert property (@(posedge bclk) disable iff (!rst_n)
    data_oe |-> (lane_en != 4'h0));

  assert_dma_select_R8: assert property (@(posedge bclk) disable iff (!rst_n)
    !dma_ack_n |-> (!dma_cs_n && core_dir == dma_wr));

endmodule

// File: tb/sim_eisa_slave_glue.sv
`timescale 1ns/1ps
module sim_eisa_slave_glue;
  localparam logic [11:0] BASE = 12'h2A5;

  logic bclk = 1'b0, rst_n = 1'b0;
  logic [11:0] io_base = BASE, addr_hi = 12'h000;
  logic aen = 1'b1, start_n = 1'b1, io_wr = 1'b0;
  logic [3:0] be_n = 4'hF;
  logic dma_ack_n = 1'b1, dma_wr = 1'b0, cycle_n = 1'b1, ready_ret_n = 1'b1;
  logic ldev_n, nows_n, core_a1, rd_strobe_n, wr_strobe_n, data_oe, dma_cs_n, core_dir, access_err;
  logic [3:0] lane_en;

  int vectors = 0, miscompares = 0;
  logic err_exp = 1'b0;
  logic done = 1'b0;

  always #10 bclk = ~bclk;

  eisa_slave_glue #(.AW(12)) u0 (
    .bclk(bclk), .rst_n(rst_n), .io_base(io_base), .addr_hi(addr_hi), .aen(aen),
    .be_n(be_n), .start_n(start_n), .io_wr(io_wr), .dma_ack_n(dma_ack_n),
    .dma_wr(dma_wr), .cycle_n(cycle_n), .ready_ret_n(ready_ret_n),
    .ldev_n(ldev_n), .nows_n(nows_n), .lane_en(lane_en), .core_a1(core_a1),
    .rd_strobe_n(rd_strobe_n), .wr_strobe_n(wr_strobe_n), .data_oe(data_oe),
    .dma_cs_n(dma_cs_n), .core_dir(core_dir), .access_err(access_err));

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s act=%0h exp=%0h t=%0t", req, act, exp, $time);
    end
  endtask

  task automatic io_access(input int mode, input logic [3:0] be, input logic wr);
    logic hit, sup, a1;
    logic [3:0] z;
    z   = ~be;
    sup = (z == 4'hF) || (z == 4'h3) || (z == 4'hC) || (z == 4'h1) ||
          (z == 4'h2) || (z == 4'h4) || (z == 4'h8);
    a1  = sup && (z[1:0] == 2'b00);
    hit = (mode == 0);
    @(posedge bclk); #1;
    addr_hi = (mode == 2) ? (BASE ^ 12'h001) : (mode == 3) ? (BASE ^ 12'h800) : BASE;
    aen = (mode == 1);
    be_n = be; io_wr = wr; start_n = 1'b1;
    #2;
    chk("R1 ldev_n", ldev_n, !hit);
    chk("R4 nows_n before start", nows_n, !hit);
    chk("R2/R3 lane_en", lane_en, sup ? z : 4'h0);
    chk("R2/R3 core_a1", core_a1, a1);
    @(posedge bclk); #1 start_n = 1'b0;
    @(posedge bclk);
    #1 chk("R4 nows_n while start low", nows_n, !hit);
    #1 start_n = 1'b1;
    #1 chk("R4 nows_n after start rise", nows_n, 1'b1);
    chk("R7 strobes first half", {rd_strobe_n, wr_strobe_n}, 2'b11);
    #9;
    chk("R6/R3 rd_strobe_n", rd_strobe_n, !(hit && sup && !wr));
    chk("R6/R3 wr_strobe_n", wr_strobe_n, !(hit && sup && wr));
    chk("R6/R3 data_oe", data_oe, hit && sup && !wr);
    if (hit && !sup) err_exp = 1'b1;
    @(posedge bclk); #2;
    chk("R7 strobes after edge", {rd_strobe_n, wr_strobe_n}, 2'b11);
    chk("R3/R10 access_err", access_err, err_exp);
    aen = 1'b1;
  endtask

  task automatic dma_burst(input logic [3:0] pat, input logic wr);
    @(posedge bclk); #1;
    dma_ack_n = 1'b0; dma_wr = wr; cycle_n = 1'b0; ready_ret_n = pat[0];
    #2;
    chk("R8 dma_cs_n", dma_cs_n, 1'b0);
    chk("R8 core_dir", core_dir, wr);
    chk("R8 lane_en", lane_en, 4'hF);
    chk("R8 core_a1", core_a1, 1'b0);
    for (int k = 0; k < 4; k++) begin
      @(posedge bclk);
      #3 chk("R7 dma first half", {rd_strobe_n, wr_strobe_n}, 2'b11);
      #9;
      chk("R9 dma rd_strobe_n", rd_strobe_n, !(!pat[k] && !wr));
      chk("R9 dma wr_strobe_n", wr_strobe_n, !(!pat[k] && wr));
      chk("R9 dma data_oe", data_oe, !pat[k] && !wr);
      #1 ready_ret_n = (k < 3) ? pat[k+1] : 1'b1;
    end
    @(posedge bclk); #1;
    dma_ack_n = 1'b1; cycle_n = 1'b1;
    #2;
    chk("R8 dma_cs_n released", dma_cs_n, 1'b1);
    chk("R7 dma strobes idle", {rd_strobe_n, wr_strobe_n}, 2'b11);
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      miscompares++;
      vectors++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

  initial begin
    #35;
    chk("R10 reset rd_strobe_n", rd_strobe_n, 1'b1);
    chk("R10 reset wr_strobe_n", wr_strobe_n, 1'b1);
    chk("R10 reset access_err", access_err, 1'b0);
    chk("R10 reset data_oe", data_oe, 1'b0);
    @(posedge bclk); #1 rst_n = 1'b1;

    for (int m = 0; m < 4; m++)
      for (int b = 0; b < 16; b++)
        for (int w = 0; w < 2; w++)
          io_access(m, b[3:0], w[0]);

    for (int p = 0; p < 16; p++) dma_burst(p[3:0], p[0] ^ p[1]);

    @(posedge bclk); #1;
    dma_ack_n = 1'b0; cycle_n = 1'b1; ready_ret_n = 1'b0; dma_wr = 1'b1;
    for (int k = 0; k < 2; k++) begin
      @(posedge bclk); #12;
      chk("R9 no request no strobe", {rd_strobe_n, wr_strobe_n}, 2'b11);
    end
    @(posedge bclk); #1 dma_ack_n = 1'b1; ready_ret_n = 1'b1;

    chk("R10 err held", access_err, err_exp);
    @(posedge bclk); #1 rst_n = 1'b0;
    #2 chk("R10 err cleared by reset", access_err, 1'b0);
    @(posedge bclk); #1 rst_n = 1'b1;
    err_exp = 1'b0;
    io_access(0, 4'b1010, 1'b0);
    io_access(0, 4'b1100, 1'b1);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule